// File: doc/BRIEF.md
# Presettable Binary/Decade Up-Down Counter

A four-bit synchronous counter that counts upward or downward, either through the full binary range (0 to 15) or as a single decade digit (0 to 9). The counting range and the direction are both chosen at run time by level inputs that are sampled at each rising clock edge. A preset input loads a parallel four-bit value while it is high. This load does not wait for the clock, and it stops counting for as long as it lasts.

An active-low carry-in acts as the clock enable. An active-low carry-out reports the terminal count for the current direction, and it responds combinationally to the carry-in. Several counters can therefore share one clock and be chained, lower carry-out to upper carry-in, to form multi-digit counters with look-ahead carry. There is no separate reset: holding preset high with a zero load value clears the counter. An unused carry-in is tied low.

The sequencer picks one action per cycle from a fixed set of names:
- `ACT_LOAD` while preset is high.
- `ACT_HOLD` while carry-in is high.
- `ACT_INC` or `ACT_DEC` for a normal step in the chosen direction.
- `ACT_WRAP_LO` for the step from the top count to zero.
- `ACT_WRAP_HI` for the step from zero to the top count.

These actions are the only transitions of the count register.

Top module: `udc4_counter`

## Requirements
- R1: While `preset_i` is 1, `count_o` equals `jam_i` in the same cycle without any clock edge, and clock edges do not advance the count.
- R2: After `preset_i` returns to 0, changes on `jam_i` have no effect. The first rising edge with `cin_n_i` = 0 steps the count from the loaded value.
- R3: While `cin_n_i` is 1 (and `preset_i` is 0), `count_o` holds its value across clock edges.
- R4: With `bin_sel_i` = 1 the count runs modulo 16. Counting up wraps 15 to 0, and counting down wraps 0 to 15.
- R5: With `bin_sel_i` = 0 the count runs as a decade. Counting up wraps 9 to 0, and counting down wraps 0 to 9.
- R6: With `up_i` = 1 each enabled edge adds one, and with `up_i` = 0 each enabled edge subtracts one.
- R7: In decade mode, a preset value from 10 to 15 counts up by one modulo 16 (15 goes to 0), and it never drives `cout_n_o` low.
- R8: `cout_n_o` is 0 exactly when `cin_n_i` is 0 and the visible count is terminal: 15 (binary, up), 9 (decade, up) or 0 (down). Otherwise it is 1. It follows `cin_n_i`, `preset_i` and `jam_i` within the same cycle.
- R9: Two instances on one clock, with the lower `cout_n_o` driving the upper `cin_n_i`, count 0 to 99 in decade mode and 0 to 255 in binary mode, up and down, including the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock, rising edge |
| preset_i | input | 1 | Level-sensitive asynchronous load and counting block, active high |
| jam_i | input | 4 | Parallel load value |
| cin_n_i | input | 1 | Carry-in / count enable, active low |
| bin_sel_i | input | 1 | 1 = binary (modulo 16), 0 = decade (modulo 10) |
| up_i | input | 1 | 1 = count up, 0 = count down |
| count_o | output | 4 | Current count |
| cout_n_o | output | 1 | Terminal-count carry-out, active low |

## Verification
The count is due one rising edge after the inputs that cause a step. The preset view and the carry-out are due in the same cycle as the stimulus, with no edge in between. The bench drives every input on the falling edge and checks the carry-out and the preset view 1 ns later, before the next rising edge. It checks the count 1 ns after that rising edge. For the two-stage chain, both digits are read at each falling edge, which is half a period after the edge that moved them, and compared with the running total.

// File: rtl/udc_pkg.sv
`timescale 1ns/1ps
package udc_pkg;

    // one action per cycle for the count register
    typedef enum logic [2:0] {
        ACT_HOLD    = 3'd0,
        ACT_LOAD    = 3'd1,
        ACT_INC     = 3'd2,
        ACT_DEC     = 3'd3,
        ACT_WRAP_LO = 3'd4,
        ACT_WRAP_HI = 3'd5
    } udc_act_e;

endpackage

// File: rtl/udc_action.sv
`timescale 1ns/1ps
module udc_action
    import udc_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int DEC_LAST = 9
) (
    input  logic             preset_i,
    input  logic             cin_n_i,
    input  logic             up_i,
    input  logic             bin_sel_i,
    input  logic [CNT_W-1:0] cnt_i,
    output udc_act_e         act_o
);
    localparam logic [CNT_W-1:0] TOP_BIN = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] TOP_DEC = DEC_LAST[CNT_W-1:0];

    logic at_top_up;
    logic at_zero;

    // decade top only wraps at DEC_LAST; non-BCD states roll on modulo 2^CNT_W
    assign at_top_up = (cnt_i == TOP_BIN) || (!bin_sel_i && (cnt_i == TOP_DEC));
    assign at_zero   = (cnt_i == '0);

    always_comb begin
        if (preset_i) begin
            act_o = ACT_LOAD;
        end else if (cin_n_i) begin
            act_o = ACT_HOLD;
        end else if (up_i) begin
            act_o = at_top_up ? ACT_WRAP_LO : ACT_INC;
        end else begin
            act_o = at_zero ? ACT_WRAP_HI : ACT_DEC;
        end
    end
endmodule

// File: rtl/udc_next.sv
`timescale 1ns/1ps
module udc_next
    import udc_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int DEC_LAST = 9
) (
    input  udc_act_e         act_i,
    input  logic             bin_sel_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] jam_i,
    output logic [CNT_W-1:0] nxt_o
);
    localparam logic [CNT_W-1:0] TOP_BIN = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] TOP_DEC = DEC_LAST[CNT_W-1:0];
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (act_i)
            ACT_LOAD:    nxt_o = jam_i;
            ACT_INC:     nxt_o = cnt_i + ONE;
            ACT_DEC:     nxt_o = cnt_i - ONE;
            ACT_WRAP_LO: nxt_o = '0;
            ACT_WRAP_HI: nxt_o = bin_sel_i ? TOP_BIN : TOP_DEC;
            default:     nxt_o = cnt_i;
        endcase
    end
endmodule

// File: rtl/udc_carry.sv
`timescale 1ns/1ps
module udc_carry #(
    parameter int CNT_W    = 4,
    parameter int DEC_LAST = 9
) (
    input  logic             cin_n_i,
    input  logic             up_i,
    input  logic             bin_sel_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             cout_n_o
);
    localparam logic [CNT_W-1:0] TOP_BIN = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] TOP_DEC = DEC_LAST[CNT_W-1:0];

    logic terminal;

    always_comb begin
        if (up_i) begin
            terminal = (cnt_i == (bin_sel_i ? TOP_BIN : TOP_DEC));
        end else begin
            terminal = (cnt_i == '0);
        end
        // look-ahead: carry-in passes straight through, no register
        cout_n_o = !(!cin_n_i && terminal);
    end
endmodule

// File: rtl/udc4_counter.sv
`timescale 1ns/1ps
module udc4_counter
    import udc_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int DEC_LAST = 9
) (
    input  logic             clk_i,
    input  logic             preset_i,
    input  logic [CNT_W-1:0] jam_i,
    input  logic             cin_n_i,
    input  logic             bin_sel_i,
    input  logic             up_i,
    output logic [CNT_W-1:0] count_o,
    output logic             cout_n_o
);
    localparam logic [CNT_W-1:0] TOP_DEC = DEC_LAST[CNT_W-1:0];
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    udc_act_e         act;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    udc_action #(.CNT_W(CNT_W), .DEC_LAST(DEC_LAST)) u_action (
        .preset_i  (preset_i),
        .cin_n_i   (cin_n_i),
        .up_i      (up_i),
        .bin_sel_i (bin_sel_i),
        .cnt_i     (cnt_q),
        .act_o     (act)
    );

    udc_next #(.CNT_W(CNT_W), .DEC_LAST(DEC_LAST)) u_next (
        .act_i     (act),
        .bin_sel_i (bin_sel_i),
        .cnt_i     (cnt_q),
        .jam_i     (jam_i),
        .nxt_o     (cnt_nxt)
    );

    // state register: preset is an asynchronous level load with priority
    always_ff @(posedge clk_i or posedge preset_i) begin
        if (preset_i) begin
            cnt_q <= jam_i;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    // output process: while preset is high the load value is seen directly
    always_comb begin
        count_o = preset_i ? jam_i : cnt_q;
    end

    udc_carry #(.CNT_W(CNT_W), .DEC_LAST(DEC_LAST)) u_carry (
        .cin_n_i   (cin_n_i),
        .up_i      (up_i),
        .bin_sel_i (bin_sel_i),
        .cnt_i     (count_o),
        .cout_n_o  (cout_n_o)
    );

    // R3
    hold_chk: assert property (@(posedge clk_i) disable iff (preset_i)
        cin_n_i |=> (count_o == $past(count_o)));

    // R6
    bin_up_step_chk: assert property (@(posedge clk_i) disable iff (preset_i)
        (!cin_n_i && up_i && bin_sel_i) |=> (count_o == ($past(count_o) + ONE)));

    // R5
    dec_down_wrap_chk: assert property (@(posedge clk_i) disable iff (preset_i)
        (!cin_n_i && !up_i && !bin_sel_i && (count_o == '0)) |=> (count_o == TOP_DEC));

    // R8
    cout_needs_cin_chk: assert property (@(posedge clk_i) disable iff (preset_i)
        !cout_n_o |-> !cin_n_i);

    // R7
    nonbcd_no_cout_chk: assert property (@(posedge clk_i) disable iff (preset_i)
        (!bin_sel_i && up_i && (count_o > TOP_DEC)) |-> cout_n_o);
endmodule

// File: tb/test_udc4_counter.sv
`timescale 1ns/1ps
module test_udc4_counter;

    logic       clk = 1'b0;
    logic       pe = 1'b1;
    logic [3:0] jam = 4'd0;
    logic [3:0] jam_hi = 4'd0;
    logic       cin_n = 1'b0;
    logic       bin = 1'b1;
    logic       up = 1'b1;
    logic [3:0] cnt_lo;
    logic [3:0] cnt_hi;
    logic       co_lo;
    logic       co_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    udc4_counter i_udc4_counter (
        .clk_i(clk), .preset_i(pe), .jam_i(jam), .cin_n_i(cin_n),
        .bin_sel_i(bin), .up_i(up), .count_o(cnt_lo), .cout_n_o(co_lo)
    );

    udc4_counter i_udc4_upper (
        .clk_i(clk), .preset_i(pe), .jam_i(jam_hi), .cin_n_i(co_lo),
        .bin_sel_i(bin), .up_i(up), .count_o(cnt_hi), .cout_n_o(co_hi)
    );

    // vector: [12] preset, [11:8] jam, [7] cin_n, [6] bin, [5] up,
    //         [4] carry-out expected before the edge, [3:0] count after the edge
    localparam int NV = 19;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 4'd7,  1'b0, 1'b1, 1'b1, 1'b1, 4'd7 },
        {1'b0, 4'd7,  1'b0, 1'b1, 1'b1, 1'b1, 4'd8 },
        {1'b0, 4'd7,  1'b0, 1'b1, 1'b1, 1'b1, 4'd9 },
        {1'b0, 4'd7,  1'b1, 1'b1, 1'b1, 1'b1, 4'd9 },
        {1'b0, 4'd7,  1'b0, 1'b0, 1'b1, 1'b0, 4'd0 },
        {1'b0, 4'd7,  1'b0, 1'b0, 1'b0, 1'b0, 4'd9 },
        {1'b0, 4'd7,  1'b0, 1'b0, 1'b0, 1'b1, 4'd8 },
        {1'b1, 4'd15, 1'b0, 1'b1, 1'b1, 1'b0, 4'd15},
        {1'b0, 4'd15, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0 },
        {1'b0, 4'd15, 1'b0, 1'b1, 1'b0, 1'b0, 4'd15},
        {1'b0, 4'd15, 1'b1, 1'b1, 1'b0, 1'b1, 4'd15},
        {1'b1, 4'd12, 1'b0, 1'b0, 1'b1, 1'b1, 4'd12},
        {1'b0, 4'd12, 1'b0, 1'b0, 1'b1, 1'b1, 4'd13},
        {1'b0, 4'd12, 1'b0, 1'b0, 1'b1, 1'b1, 4'd14},
        {1'b0, 4'd12, 1'b0, 1'b0, 1'b1, 1'b1, 4'd15},
        {1'b0, 4'd12, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0 },
        {1'b1, 4'd0,  1'b1, 1'b1, 1'b1, 1'b1, 4'd0 },
        {1'b1, 4'd5,  1'b0, 1'b1, 1'b1, 1'b1, 4'd5 },
        {1'b0, 4'd10, 1'b0, 1'b1, 1'b0, 1'b1, 4'd4 }
    };

    function automatic string vtag(int i);
        case (i)
            0, 7, 11, 16, 17: return "R1";
            18:               return "R2";
            3, 10:            return "R3";
            8, 9:             return "R4";
            4, 5:             return "R5";
            1, 2, 6:          return "R6";
            default:          return "R7";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // two-stage chain: clear both digits, then step n times and compare the total
    task automatic chain_run(bit bin_m, bit up_m, int modulus, string tag);
        @(negedge clk);
        pe = 1'b1; jam = 4'd0; jam_hi = 4'd0; cin_n = 1'b0;
        bin = bin_m; up = up_m;
        @(negedge clk);
        pe = 1'b0;
        for (int k = 1; k <= modulus + 3; k++) begin
            int exp_v;
            int act_v;
            @(negedge clk);
            exp_v = up_m ? (k % modulus) : ((modulus - (k % modulus)) % modulus);
            act_v = bin_m ? ((int'(cnt_hi) << 4) | int'(cnt_lo))
                          : (int'(cnt_hi) * 10 + int'(cnt_lo));
            check(tag, "chain value", act_v, exp_v);
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // table walk: drive at the falling edge, carry and preset view 1 ns later,
        // count 1 ns after the following rising edge
        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            v = VEC[i];
            @(negedge clk);
            pe = v[12]; jam = v[11:8]; cin_n = v[7]; bin = v[6]; up = v[5];
            #1;
            check("R8", "carry-out", int'(co_lo), int'(v[4]));
            if (v[12]) check("R1", "preset view", int'(cnt_lo), int'(v[11:8]));
            @(posedge clk);
            #1;
            check(vtag(i), "count", int'(cnt_lo), int'(v[3:0]));
        end

        // R8: carry-out follows carry-in within the cycle, no edge between
        @(negedge clk);
        pe = 1'b1; jam = 4'd9; bin = 1'b0; up = 1'b1; cin_n = 1'b1;
        #1;
        check("R8", "carry-out with cin high", int'(co_lo), 1);
        cin_n = 1'b0;
        #1;
        check("R8", "carry-out after cin low", int'(co_lo), 0);

        // R1: a change of jam while preset is high is followed at once
        jam = 4'd3;
        #0.5;
        check("R1", "preset follows jam", int'(cnt_lo), 3);

        // R2: release, then jam changes are ignored and the count steps from 3
        @(negedge clk);
        pe = 1'b0; up = 1'b1; bin = 1'b1;
        #1;
        jam = 4'd14;
        @(posedge clk);
        #1;
        check("R2", "first step after release", int'(cnt_lo), 4);

        chain_run(1'b0, 1'b1, 100, "R9");
        chain_run(1'b0, 1'b0, 100, "R9");
        chain_run(1'b1, 1'b1, 256, "R9");
        chain_run(1'b1, 1'b0, 256, "R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule